// File: doc/BRIEF.md
# Device Interrupt Pin Mapper

This block holds the interrupt routing set-up for a group of on-chip device slots and answers, at any moment, which shared interrupt line (one of eight, numbered 0 to 7) a given device pin lands on. Each slot from 25 to 31 owns a 16-bit route word. Inside that word, every one of the four interrupt pins (INTA to INTD) has a small field that names its line. Slot 30 is the exception. It is the bridge to the downstream bus, so its word is fixed at zero and its pins always use lines 4 to 7. Slots 0 to 24 have no route word. They follow a rotating default that only uses lines 4 to 7, which keeps lines 0 to 3 free for other users.

Software reaches the route words through a small byte-addressed, little-endian access port. The port carries an address, a length of one to four bytes, and write data. An access that would run past the end of the 16-byte bank is cut short at the last byte. Reads answer one cycle later through a two-state response machine. A separate combinational lookup port takes a slot number and a pin and returns the line number. This lookup reflects a write as soon as the clock edge that accepts the write has passed.

The response machine has two states. In `ACC_IDLE` no read data is presented. In `ACC_RESP` read data is presented. Any accepted read moves the machine to `ACC_RESP`, from either state. Any cycle without a read moves it to `ACC_IDLE`, from either state. Writes never enter `ACC_RESP`.

Top module: `irq_pin_router`

## Requirements
- R1: After reset, every route word that can be written reads 0x3210. The word of slot 30 and the reserved bytes 14 and 15 read zero. `acc_rvalid` is low and `acc_rdata` is zero.
- R2: For slots 25 to 29 and 31, the line for pin p (0 = INTA, 1 = INTB, 2 = INTC, 3 = INTD) is bits [4p+2:4p] of that slot's route word. Bit 4p+3 is ignored.
- R3: Slot 30 maps pin p to line p+4, whatever has been written. Its word (bytes 10 and 11) always reads zero, and writes to it are discarded.
- R4: Slots 0 to 24 map pin p to line ((slot + p) mod 4) + 4.
- R5: The route word of slot s sits at byte offset 2*(s-25), with its low byte at the lower address. Bytes 14 and 15 are reserved: they read zero and ignore writes.
- R6: Only the low 4 bits of `acc_addr` select a byte. The upper bits are ignored.
- R7: `acc_len` encodes the byte count minus one (0 means 1 byte, 3 means 4 bytes). The access is clipped to min(count, 16 - offset) bytes. Lane i carries byte offset+i. Clipped lanes are not written, and on reads they return zero. The access never wraps to offset 0.
- R8: A read accepted at a rising edge shows `acc_rvalid` high and its data on `acc_rdata` for the following cycle only. In any other cycle `acc_rvalid` is low and `acc_rdata` is zero.
- R9: A write accepted at a rising edge changes the lookup result from that edge on, for every slot it affects. When no write is accepted and the lookup inputs are stable, the lookup result stays unchanged.
- R10: Back-to-back reads keep the machine in `ACC_RESP`, and each cycle presents the data of the read accepted one edge before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access request present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address; only the low 4 bits are used |
| acc_len | input | 2 | Byte count minus one |
| acc_wdata | input | 32 | Write data, lane 0 in bits [7:0] |
| acc_rvalid | output | 1 | Read data valid |
| acc_rdata | output | 32 | Read data, lane 0 in bits [7:0] |
| lk_slot | input | 5 | Device slot to look up |
| lk_pin | input | 2 | Interrupt pin to look up (0 = INTA) |
| lk_pirq | output | 3 | Shared interrupt line for that slot and pin |

## Verification
The lookup is purely combinational, so its result is due in the same cycle as its inputs. The bench therefore checks it one nanosecond after changing the slot and pin. A write takes effect at the rising edge that accepts it. The bench drives the write on a falling edge and checks the lookup and later reads only after the next falling edge. Read data is due exactly one rising edge after acceptance. The bench drives each read on a falling edge and samples `acc_rvalid` and `acc_rdata` on the next falling edge, including a back-to-back pair where the second result must follow the first by one cycle.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;

    localparam int SLOT_W        = 5;
    localparam int PIN_W         = 2;
    localparam int PIRQ_W        = 3;
    localparam int NUM_PINS      = 1 << PIN_W;
    localparam int FIRST_SLOT    = 25;
    localparam int NUM_ROUTED    = 7;
    localparam int BRIDGE_SLOT   = 30;
    localparam int ROUTE_BITS    = 16;
    localparam int ROUTE_BYTES   = ROUTE_BITS / 8;
    localparam int FIELD_SHIFT   = 4;
    localparam logic [PIRQ_W-1:0] FIELD_MASK = 3'h7;
    localparam logic [ROUTE_BITS-1:0] ROUTE_DEFAULT = 16'h3210;
    localparam int DEFAULT_GROUP = 4;
    localparam int BANK_BYTES    = 16;
    localparam int OFF_W         = $clog2(BANK_BYTES);
    localparam int LANES         = 4;
    localparam int LEN_W         = $clog2(LANES);
    localparam int DATA_W        = LANES * 8;
    localparam int BANK_W        = BANK_BYTES * 8;
    localparam int ROUTED_W      = NUM_ROUTED * ROUTE_BITS;
    localparam int ROUTE_IDX_W   = $clog2(NUM_ROUTED);

    typedef enum logic [0:0] {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_e;

    // A bank byte has storage only if it belongs to a route word other than the bridge's.
    function automatic bit byte_writable(input int off);
        int idx;
        idx = off / ROUTE_BYTES;
        return (idx < NUM_ROUTED) && ((FIRST_SLOT + idx) != BRIDGE_SLOT);
    endfunction

    function automatic logic [7:0] byte_reset_value(input int off);
        if (!byte_writable(off)) begin
            return 8'h00;
        end
        return ROUTE_DEFAULT[(off % ROUTE_BYTES) * 8 +: 8];
    endfunction

endpackage

// File: rtl/irq_route_bytes.sv
`timescale 1ns/1ps
module irq_route_bytes
    import irq_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_BYTES-1:0] wr_en,
    input  logic [BANK_W-1:0] wr_data,
    output logic [BANK_W-1:0] bank_q
);

    for (genvar g = 0; g < BANK_BYTES; g++) begin : g_byte
        localparam bit         HAS_STORE = byte_writable(g);
        localparam logic [7:0] RST_VAL   = byte_reset_value(g);
        if (HAS_STORE) begin : g_store
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= RST_VAL;
                end else if (wr_en[g]) begin
                    q <= wr_data[g*8 +: 8];
                end
            end
            assign bank_q[g*8 +: 8] = q;
        end else begin : g_zero
            logic unused_lane;
            assign unused_lane = wr_en[g] ^ (^wr_data[g*8 +: 8]);
            assign bank_q[g*8 +: 8] = 8'h00;
        end
    end

endmodule

// File: rtl/irq_route_access.sv
`timescale 1ns/1ps
module irq_route_access
    import irq_route_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [LEN_W-1:0]      acc_len,
    input  logic [DATA_W-1:0]     acc_wdata,
    input  logic [BANK_W-1:0]     bank_q,
    output logic [BANK_BYTES-1:0] wr_en,
    output logic [BANK_W-1:0]     wr_data,
    output logic                  acc_rvalid,
    output logic [DATA_W-1:0]     acc_rdata
);

    acc_state_e        state_q, state_d;
    logic [OFF_W-1:0]  off;
    logic              rd_req, wr_req;
    int                eff;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rdata_q;
    logic              unused_addr_hi;

    assign off            = acc_addr[OFF_W-1:0];
    assign unused_addr_hi = ^acc_addr[ADDR_W-1:OFF_W];
    assign rd_req         = acc_valid && !acc_write;
    assign wr_req         = acc_valid && acc_write;

    // Clip the access so it ends at the last byte of the bank.
    always_comb begin
        int req_bytes;
        int room;
        req_bytes = int'(acc_len) + 1;
        room      = BANK_BYTES - int'(off);
        eff       = (req_bytes < room) ? req_bytes : room;
    end

    // Steer write lanes onto bank bytes.
    always_comb begin
        wr_en   = '0;
        wr_data = '0;
        for (int b = 0; b < BANK_BYTES; b++) begin
            int d;
            d = b - int'(off);
            if (wr_req && (d >= 0) && (d < eff)) begin
                wr_en[b]          = 1'b1;
                wr_data[b*8 +: 8] = acc_wdata[d*8 +: 8];
            end
        end
    end

    // Gather read lanes; clipped lanes stay zero.
    always_comb begin
        rd_next = '0;
        for (int i = 0; i < LANES; i++) begin
            if (i < eff) begin
                rd_next[i*8 +: 8] = bank_q[(int'(off) + i)*8 +: 8];
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: state_d = rd_req ? ACC_RESP : ACC_IDLE;
            ACC_RESP: state_d = rd_req ? ACC_RESP : ACC_IDLE;
            default:  state_d = ACC_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rd_req ? rd_next : '0;
        end
    end

    assign acc_rvalid = (state_q == ACC_RESP);
    assign acc_rdata  = rdata_q;

endmodule

// File: rtl/irq_route_lookup.sv
`timescale 1ns/1ps
module irq_route_lookup
    import irq_route_pkg::*;
(
    input  logic [ROUTED_W-1:0] route_q,
    input  logic [SLOT_W-1:0]   lk_slot,
    input  logic [PIN_W-1:0]    lk_pin,
    output logic [PIRQ_W-1:0]   lk_pirq
);

    logic                   is_bridge, is_routed;
    logic [SLOT_W-1:0]      rel;
    logic [ROUTE_IDX_W-1:0] idx;
    logic [ROUTE_BITS-1:0]  word;
    logic [ROUTE_BITS-1:0]  shifted;

    assign is_bridge = (int'(lk_slot) == BRIDGE_SLOT);
    assign is_routed = (int'(lk_slot) >= FIRST_SLOT) &&
                       (int'(lk_slot) <  FIRST_SLOT + NUM_ROUTED);
    assign rel       = lk_slot - SLOT_W'(FIRST_SLOT);
    assign idx       = is_routed ? rel[ROUTE_IDX_W-1:0] : '0;
    assign word      = route_q[int'(idx)*ROUTE_BITS +: ROUTE_BITS];
    assign shifted   = word >> (int'(lk_pin) * FIELD_SHIFT);

    always_comb begin
        if (is_bridge) begin
            lk_pirq = PIRQ_W'(int'(lk_pin) + DEFAULT_GROUP);
        end else if (is_routed) begin
            lk_pirq = shifted[PIRQ_W-1:0] & FIELD_MASK;
        end else begin
            lk_pirq = PIRQ_W'(((int'(lk_slot) + int'(lk_pin)) % NUM_PINS) + DEFAULT_GROUP);
        end
    end

endmodule

// File: rtl/irq_pin_router.sv
`timescale 1ns/1ps
module irq_pin_router
    import irq_route_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_len,
    input  logic [31:0]       acc_wdata,
    output logic              acc_rvalid,
    output logic [31:0]       acc_rdata,
    input  logic [4:0]        lk_slot,
    input  logic [1:0]        lk_pin,
    output logic [2:0]        lk_pirq
);

    logic [BANK_BYTES-1:0] wr_en;
    logic [BANK_W-1:0]     wr_data;
    logic [BANK_W-1:0]     bank_q;

    irq_route_access #(.ADDR_W(ADDR_W)) u_access (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_addr   (acc_addr),
        .acc_len    (acc_len),
        .acc_wdata  (acc_wdata),
        .bank_q     (bank_q),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .acc_rvalid (acc_rvalid),
        .acc_rdata  (acc_rdata)
    );

    irq_route_bytes u_bytes (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .bank_q  (bank_q)
    );

    irq_route_lookup u_lookup (
        .route_q (bank_q[ROUTED_W-1:0]),
        .lk_slot (lk_slot),
        .lk_pin  (lk_pin),
        .lk_pirq (lk_pirq)
    );

endmodule

// File: rtl/irq_pin_router_chk.sv
`timescale 1ns/1ps
module irq_pin_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic       acc_write,
    input logic       acc_rvalid,
    input logic [31:0] acc_rdata,
    input logic [4:0] lk_slot,
    input logic [1:0] lk_pin,
    input logic [2:0] lk_pirq
);

    p_rvalid_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> acc_rvalid);

    p_rvalid_only_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rvalid |-> $past(acc_valid && !acc_write));

    p_rdata_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rvalid |-> (acc_rdata == 32'h0));

    p_bridge_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_slot == 5'd30) |-> (lk_pirq == {1'b1, lk_pin}));

    p_unrouted_rotate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_slot < 5'd25) |-> (lk_pirq == {1'b1, 2'(lk_slot[1:0] + lk_pin)}));

    p_hold_without_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_write) |=>
            (!($stable(lk_slot) && $stable(lk_pin)) || $stable(lk_pirq)));

endmodule

bind irq_pin_router irq_pin_router_chk u_chk (.*);

// File: tb/irq_pin_router_test.sv
`timescale 1ns/1ps
module irq_pin_router_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [1:0]  acc_len = '0;
    logic [31:0] acc_wdata = '0;
    logic        acc_rvalid;
    logic [31:0] acc_rdata;
    logic [4:0]  lk_slot = '0;
    logic [1:0]  lk_pin = '0;
    logic [2:0]  lk_pirq;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit [7:0] model [16];

    always #5 clk = ~clk;

    irq_pin_router #(.ADDR_W(8)) uut (.*);

    function automatic bit writable(input int off);
        return (off / 2 < 7) && (off / 2 != 5);
    endfunction

    function automatic int clip_len(input int addr, input int len);
        int off;
        int n;
        off = addr % 16;
        n = len + 1;
        return (n < 16 - off) ? n : 16 - off;
    endfunction

    function automatic int exp_read(input int addr, input int len);
        int off;
        int v;
        off = addr % 16;
        v = 0;
        for (int i = 0; i < clip_len(addr, len); i++) v |= int'(model[off + i]) << (8 * i);
        return v;
    endfunction

    function automatic int exp_pirq(input int s, input int p);
        int w;
        if (s == 30) return p + 4;
        if (s >= 25) begin
            w = int'(model[2*(s-25)]) | (int'(model[2*(s-25)+1]) << 8);
            return (w >> (4 * p)) & 7;
        end
        return ((s + p) % 4) + 4;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input int addr, input int len, input int data);
        int off;
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_addr = 8'(addr); acc_len = 2'(len); acc_wdata = data;
        @(negedge clk);
        acc_valid = 0; acc_write = 0;
        off = addr % 16;
        for (int i = 0; i < clip_len(addr, len); i++)
            if (writable(off + i)) model[off + i] = 8'(data >> (8 * i));
    endtask

    task automatic do_read(input int addr, input int len, input string req);
        @(negedge clk);
        acc_valid = 1; acc_write = 0; acc_addr = 8'(addr); acc_len = 2'(len);
        @(negedge clk);
        acc_valid = 0;
        check("R8 rvalid", int'(acc_rvalid), 1);
        check(req, int'(acc_rdata), exp_read(addr, len));
    endtask

    task automatic sweep_reads(input string req);
        for (int a = 0; a < 16; a++)
            for (int l = 0; l < 4; l++) do_read(a, l, req);
    endtask

    task automatic sweep_lookup(input string routed_req);
        for (int s = 0; s < 32; s++)
            for (int p = 0; p < 4; p++) begin
                lk_slot = 5'(s); lk_pin = 2'(p);
                #1;
                if (s == 30)      check("R3 bridge lookup", int'(lk_pirq), exp_pirq(s, p));
                else if (s >= 25) check(routed_req, int'(lk_pirq), exp_pirq(s, p));
                else              check("R4 default lookup", int'(lk_pirq), exp_pirq(s, p));
            end
    endtask

    initial begin
        for (int i = 0; i < 16; i++)
            model[i] = writable(i) ? ((i % 2 == 0) ? 8'h10 : 8'h32) : 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 rvalid idle", int'(acc_rvalid), 0);
        check("R1 rdata idle", int'(acc_rdata), 0);
        sweep_reads("R1 R5 R7 reset read");
        sweep_lookup("R2 reset lookup");

        // Program every route word byte by byte; bit 3 of each field set to test the mask.
        for (int k = 0; k < 7; k++) begin
            int w;
            w = 0;
            for (int p = 0; p < 4; p++) w |= (8 | ((k * 3 + p * 5) & 7)) << (4 * p);
            do_write(2 * k, 0, w & 8'hff);
            do_write(2 * k + 1, 0, (w >> 8) & 8'hff);
        end
        sweep_lookup("R2 R9 lookup after write");
        check("R9 rvalid after writes", int'(acc_rvalid), 0);

        // Bridge word discarded, reserved bytes discarded.
        do_write(10, 1, 32'h0000_7654);
        do_write(14, 1, 32'h0000_BEEF);
        do_read(10, 3, "R3 R5 bridge and reserved read zero");
        sweep_lookup("R3 R9 lookup after bridge write");

        // Upper address bits ignored.
        do_write(8'hF2, 0, 32'h0000_0067);
        do_read(2, 0, "R6 masked address write");
        do_read(8'h42, 1, "R6 masked address read");

        // Clipping at end of bank: no wrap into offset 0.
        do_write(13, 3, 32'hAABB_CC45);
        do_read(12, 3, "R7 clipped write");
        do_read(0, 0, "R7 no wrap to offset 0");
        do_read(13, 3, "R7 clipped read lanes zero");
        do_write(1, 3, 32'h1357_9BDF);
        sweep_reads("R5 R7 read after multi-byte write");
        sweep_lookup("R2 R9 lookup after multi-byte write");

        // Back-to-back reads.
        @(negedge clk);
        acc_valid = 1; acc_write = 0; acc_addr = 8'd0; acc_len = 2'd3;
        @(negedge clk);
        check("R10 first rvalid", int'(acc_rvalid), 1);
        check("R10 first data", int'(acc_rdata), exp_read(0, 3));
        acc_addr = 8'd4; acc_len = 2'd1;
        @(negedge clk);
        acc_valid = 0;
        check("R10 second rvalid", int'(acc_rvalid), 1);
        check("R10 second data", int'(acc_rdata), exp_read(4, 1));
        @(negedge clk);
        check("R8 rvalid drops", int'(acc_rvalid), 0);
        check("R8 rdata drops", int'(acc_rdata), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule